// File: doc/BRIEF.md
# Blocked Loop-Nest Coordinate Sequencer

This block walks the iteration space of a convolution layer that has been tiled into blocks. The space has six dimensions: kernel column, kernel row, output column, output row, input channel and output kernel. Each dimension may be cut into up to three nested levels, and a run-time list gives the order of the loop slots, innermost first. The block emits one coordinate tuple per accepted handshake. With each tuple it gives the matching input-image position and two flags. The flags tell a downstream accumulator that the current output has received its first partial product, or its final one.

Software loads the slot list, the slot count and the level sizes on the configuration inputs, then pulses `start`. The block captures the configuration and checks it in the next cycle. It then streams tuples under `out_valid`/`out_ready` until the whole space has been covered, and pulses `done`. If the configuration is inconsistent, the block raises `cfg_err` and streams nothing.

Top module: `loopnest_seq`

## Requirements
- R1: After reset, `out_valid`, `done` and `cfg_err` are all 0.
- R2: A `start` seen while idle captures `cfg_nloops`, `cfg_order` and `cfg_size`. For a valid configuration `out_valid` is 0 in the following cycle and 1 in the cycle after that.
- R3: Slot i of `cfg_order` is bits [5i+4:5i], with the dimension code in the low 3 bits (0 kernel column, 1 kernel row, 2 output column, 3 output row, 4 input channel, 5 output kernel) and the level in the top 2 bits. The size of dimension d at level l is `cfg_size[(3d+l)*16 +: 16]`. Slot 0 advances fastest. A slot at level 0 steps by 1 and a slot at level l steps by the level l-1 size, each running up to its own level size. A dimension's coordinate is the sum of its slots' offsets, and every point of the space is emitted exactly once.
- R4: A dimension that appears in no slot holds coordinate 0 for the whole run.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and every coordinate output hold their values.
- R6: For each output (x, y, k), `red_first` is 1 on its first emitted tuple and `red_last` is 1 on its final one, counted over all channel, kernel-row and kernel-column steps. Both are 0 on every other tuple of that output.
- R7: `in_x` equals x + fw and `in_y` equals y + fh, computed without overflow.
- R8: In the cycle after the final tuple is accepted, `done` is 1 for exactly one cycle and `out_valid` is 0.
- R9: A `start` seen while a run is in progress is ignored. The run continues with the captured configuration, even if the configuration inputs change.
- R10: A used level size of zero, or a level size that is not an exact multiple of the size one level below it, sets `cfg_err` two cycles after `start`, and `out_valid` stays 0. `cfg_err` clears when the next `start` is captured.
- R11: Any of the following also sets `cfg_err` with no tuples emitted: a slot count of 0, a dimension code above 5, a level of 3, the same dimension and level in two slots, or a level used without the level below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the configuration and begin a run |
| cfg_nloops | input | 5 | Number of used loop slots (1 to 18) |
| cfg_order | input | 90 | Loop slot list, innermost first, 5 bits per slot |
| cfg_size | input | 288 | Level sizes, 16 bits per dimension and level |
| out_valid | output | 1 | A coordinate tuple is presented |
| out_ready | input | 1 | The consumer accepts the tuple |
| x | output | 16 | Output column |
| y | output | 16 | Output row |
| c | output | 16 | Input channel |
| k | output | 16 | Output kernel |
| fw | output | 16 | Kernel column offset |
| fh | output | 16 | Kernel row offset |
| in_x | output | 17 | Input image column, x + fw |
| in_y | output | 17 | Input image row, y + fh |
| red_first | output | 1 | First reduction step of the current output |
| red_last | output | 1 | Final reduction step of the current output |
| done | output | 1 | One-cycle pulse after the last tuple is accepted |
| cfg_err | output | 1 | The captured configuration was rejected |

## Verification
The plain single-level nest in the default order confirms the basic odometer and the input-position sum. A nest with two-level splits and shuffled slots shows that an outer slot steps by the inner block size rather than by one. A three-level split whose levels are listed out of order, and a nest that leaves four dimensions unused, exercise level arithmetic that does not depend on order and the zero coordinates. Random nests with random back-pressure separate correct holding and reduction flags from flags that only work when every tuple is accepted at once. Each malformed configuration triggers exactly one rejection rule.

// File: rtl/lnseq_pkg.sv
package lnseq_pkg;

    localparam int CW     = 16;
    localparam int NDIM   = 6;
    localparam int NLVL   = 3;
    localparam int NSLOT  = NDIM * NLVL;
    localparam int DIM_W  = $clog2(NDIM);
    localparam int LVL_W  = $clog2(NLVL + 1);
    localparam int SLOT_W = DIM_W + LVL_W;
    localparam int LOOP_W = $clog2(NSLOT + 1);

    typedef logic [CW-1:0] ctr_t;

    typedef enum logic [DIM_W-1:0] {
        D_FW = 3'd0,
        D_FH = 3'd1,
        D_X  = 3'd2,
        D_Y  = 3'd3,
        D_C  = 3'd4,
        D_K  = 3'd5
    } dim_e;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [DIM_W-1:0] dim;
    } slot_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_RUN
    } seq_state_e;

    // Dimensions summed into one output value.
    function automatic logic is_red(input logic [DIM_W-1:0] d);
        return (d == D_FW) || (d == D_FH) || (d == D_C);
    endfunction

endpackage

// File: rtl/lnseq_cfg_check.sv
module lnseq_cfg_check
    import lnseq_pkg::*;
(
    input  slot_t             order [NSLOT],
    input  logic [LOOP_W-1:0] nloops,
    input  ctr_t              size  [NDIM][NLVL],
    output logic              ok,
    output logic [NSLOT-1:0]  live,
    output ctr_t              step  [NSLOT],
    output ctr_t              lim   [NSLOT]
);

    logic [NLVL-1:0] seen [NDIM];

    always_comb begin
        for (int d = 0; d < NDIM; d++) seen[d] = '0;
        ok = (nloops != '0) && (int'(nloops) <= NSLOT);

        // Slot decode: range, uniqueness, stride and last offset.
        for (int s = 0; s < NSLOT; s++) begin
            live[s] = (s < int'(nloops));
            step[s] = ctr_t'(1);
            lim[s]  = '0;
            if (live[s]) begin
                if (int'(order[s].dim) >= NDIM || int'(order[s].lvl) >= NLVL) begin
                    ok = 1'b0;
                end else begin
                    if (seen[order[s].dim][order[s].lvl]) ok = 1'b0;
                    seen[order[s].dim][order[s].lvl] = 1'b1;
                    if (order[s].lvl != '0)
                        step[s] = size[order[s].dim][order[s].lvl - 1'b1];
                    lim[s] = size[order[s].dim][order[s].lvl] - step[s];
                end
            end
        end

        // Level chain per dimension: contiguous, nonzero, exact multiples.
        for (int d = 0; d < NDIM; d++) begin
            for (int l = 0; l < NLVL; l++) begin
                if (seen[d][l]) begin
                    if (size[d][l] == '0) ok = 1'b0;
                    if (l > 0) begin
                        if (!seen[d][l-1])
                            ok = 1'b0;
                        else if (size[d][l-1] != '0 &&
                                 (size[d][l] % size[d][l-1]) != '0)
                            ok = 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lnseq_counters.sv
module lnseq_counters
    import lnseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    input  logic [NSLOT-1:0] live,
    input  ctr_t             step [NSLOT],
    input  ctr_t             lim  [NSLOT],
    output ctr_t             off  [NSLOT],
    output logic [NSLOT-1:0] at_lim,
    output logic             all_lim
);

    logic [NSLOT-1:0] bump;

    // Ripple enable: a slot moves when every slot inside it wraps.
    always_comb begin
        logic c;
        c = adv;
        for (int s = 0; s < NSLOT; s++) begin
            bump[s] = c && live[s];
            c       = c && at_lim[s];
        end
    end

    assign all_lim = &at_lim;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign at_lim[s] = !live[s] || (off[s] == lim[s]);

        always_ff @(posedge clk) begin
            if (rst || clear)
                off[s] <= '0;
            else if (bump[s])
                off[s] <= at_lim[s] ? '0 : off[s] + step[s];
        end
    end

endmodule

// File: rtl/lnseq_coord.sv
module lnseq_coord
    import lnseq_pkg::*;
(
    input  slot_t            order [NSLOT],
    input  logic [NSLOT-1:0] live,
    input  ctr_t             off   [NSLOT],
    input  logic [NSLOT-1:0] at_lim,
    output ctr_t             coord [NDIM],
    output logic             red_first,
    output logic             red_last
);

    always_comb begin
        for (int d = 0; d < NDIM; d++) coord[d] = '0;
        red_first = 1'b1;
        red_last  = 1'b1;
        for (int s = 0; s < NSLOT; s++) begin
            if (live[s] && int'(order[s].dim) < NDIM) begin
                coord[order[s].dim] = coord[order[s].dim] + off[s];
                if (is_red(order[s].dim)) begin
                    red_first = red_first && (off[s] == '0);
                    red_last  = red_last && at_lim[s];
                end
            end
        end
    end

endmodule

// File: rtl/loopnest_seq.sv
module loopnest_seq
    import lnseq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [LOOP_W-1:0]       cfg_nloops,
    input  logic [NSLOT*SLOT_W-1:0] cfg_order,
    input  logic [NDIM*NLVL*CW-1:0] cfg_size,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [CW-1:0]           x,
    output logic [CW-1:0]           y,
    output logic [CW-1:0]           c,
    output logic [CW-1:0]           k,
    output logic [CW-1:0]           fw,
    output logic [CW-1:0]           fh,
    output logic [CW:0]             in_x,
    output logic [CW:0]             in_y,
    output logic                    red_first,
    output logic                    red_last,
    output logic                    done,
    output logic                    cfg_err
);

    seq_state_e        state;
    logic [LOOP_W-1:0] nl_q;
    slot_t             ord_q  [NSLOT];
    ctr_t              size_q [NDIM][NLVL];

    logic              cfg_ok;
    logic [NSLOT-1:0]  live_w;
    ctr_t              step_w [NSLOT];
    ctr_t              lim_w  [NSLOT];
    ctr_t              off_w  [NSLOT];
    logic [NSLOT-1:0]  atl_w;
    logic              all_w;
    ctr_t              coord_w [NDIM];
    logic              fire;
    logic              load_cyc;

    assign out_valid = (state == S_RUN);
    assign fire      = out_valid && out_ready;
    assign load_cyc  = (state == S_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            nl_q    <= '0;
            done    <= 1'b0;
            cfg_err <= 1'b0;
            for (int s = 0; s < NSLOT; s++) ord_q[s] <= '0;
            for (int d = 0; d < NDIM; d++)
                for (int l = 0; l < NLVL; l++) size_q[d][l] <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    nl_q    <= cfg_nloops;
                    cfg_err <= 1'b0;
                    for (int s = 0; s < NSLOT; s++)
                        ord_q[s] <= slot_t'(cfg_order[s*SLOT_W +: SLOT_W]);
                    for (int d = 0; d < NDIM; d++)
                        for (int l = 0; l < NLVL; l++)
                            size_q[d][l] <= cfg_size[(d*NLVL + l)*CW +: CW];
                    state <= S_LOAD;
                end
                S_LOAD: begin
                    if (cfg_ok) begin
                        state <= S_RUN;
                    end else begin
                        cfg_err <= 1'b1;
                        state   <= S_IDLE;
                    end
                end
                S_RUN: if (fire && all_w) begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    lnseq_cfg_check u_check (
        .order  (ord_q),
        .nloops (nl_q),
        .size   (size_q),
        .ok     (cfg_ok),
        .live   (live_w),
        .step   (step_w),
        .lim    (lim_w)
    );

    lnseq_counters u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear   (load_cyc),
        .adv     (fire),
        .live    (live_w),
        .step    (step_w),
        .lim     (lim_w),
        .off     (off_w),
        .at_lim  (atl_w),
        .all_lim (all_w)
    );

    lnseq_coord u_coord (
        .order     (ord_q),
        .live      (live_w),
        .off       (off_w),
        .at_lim    (atl_w),
        .coord     (coord_w),
        .red_first (red_first),
        .red_last  (red_last)
    );

    assign fw   = coord_w[D_FW];
    assign fh   = coord_w[D_FH];
    assign x    = coord_w[D_X];
    assign y    = coord_w[D_Y];
    assign c    = coord_w[D_C];
    assign k    = coord_w[D_K];
    assign in_x = {1'b0, x} + {1'b0, fw};
    assign in_y = {1'b0, y} + {1'b0, fh};

endmodule

// File: rtl/lnseq_chk.sv
module lnseq_chk
    import lnseq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          out_valid,
    input logic          out_ready,
    input logic [CW-1:0] x,
    input logic [CW-1:0] y,
    input logic [CW-1:0] c,
    input logic [CW-1:0] k,
    input logic [CW-1:0] fw,
    input logic [CW-1:0] fh,
    input logic          done,
    input logic          cfg_err
);

    // R5
    hold_coords_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(x) && $stable(y) && $stable(c) &&
             $stable(k) && $stable(fw) && $stable(fh)));

    // R5
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_ready));

    // R8
    done_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(out_valid && out_ready) && !out_valid));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !out_valid);

endmodule

bind loopnest_seq lnseq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .x         (x),
    .y         (y),
    .c         (c),
    .k         (k),
    .fw        (fw),
    .fh        (fh),
    .done      (done),
    .cfg_err   (cfg_err)
);

// File: tb/sim_loopnest_seq.sv
module sim_loopnest_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  cfg_nloops = '0;
    logic [89:0] cfg_order = '0;
    logic [287:0] cfg_size = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] x, y, c, k, fw, fh;
    logic [16:0] in_x, in_y;
    logic        red_first, red_last, done, cfg_err;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    int sz  [6][3];
    int nlv [6];
    int n;
    int sd  [18];
    int sl  [18];
    int seen_map [longint];

    always #2 clk = ~clk;

    loopnest_seq u0 (
        .clk(clk), .rst(rst), .start(start),
        .cfg_nloops(cfg_nloops), .cfg_order(cfg_order), .cfg_size(cfg_size),
        .out_valid(out_valid), .out_ready(out_ready),
        .x(x), .y(y), .c(c), .k(k), .fw(fw), .fh(fh),
        .in_x(in_x), .in_y(in_y),
        .red_first(red_first), .red_last(red_last),
        .done(done), .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int stp(input int s);
        return (sl[s] == 0) ? 1 : sz[sd[s]][sl[s]-1];
    endfunction

    task automatic clear_cfg();
        for (int d = 0; d < 6; d++) begin
            nlv[d] = 0;
            for (int l = 0; l < 3; l++) sz[d][l] = 0;
        end
        n = 0;
    endtask

    task automatic build_slots(input bit shuffle);
        n = 0;
        for (int d = 0; d < 6; d++)
            for (int l = 0; l < nlv[d]; l++) begin
                sd[n] = d; sl[n] = l; n++;
            end
        if (shuffle)
            for (int i = n - 1; i > 0; i--) begin
                int j, td, tl;
                j = int'($urandom % (i + 1));
                td = sd[i]; tl = sl[i];
                sd[i] = sd[j]; sl[i] = sl[j];
                sd[j] = td; sl[j] = tl;
            end
    endtask

    task automatic apply_cfg();
        cfg_nloops = 5'(n);
        for (int s = 0; s < 18; s++)
            cfg_order[s*5 +: 5] = (s < n) ? {2'(sl[s]), 3'(sd[s])} : 5'd0;
        for (int d = 0; d < 6; d++)
            for (int l = 0; l < 3; l++)
                cfg_size[(d*3 + l)*16 +: 16] = 16'(sz[d][l]);
    endtask

    task automatic rand_cfg();
        for (int attempt = 0; attempt < 200; attempt++) begin
            int total;
            total = 1;
            for (int d = 0; d < 6; d++) begin
                int r, base;
                r = int'($urandom % 8);
                nlv[d] = (r < 2) ? 0 : (r < 5) ? 1 : (r < 7) ? 2 : 3;
                base = 1;
                for (int l = 0; l < 3; l++) begin
                    if (l < nlv[d]) begin
                        base = base * (1 + int'($urandom % 3));
                        sz[d][l] = base;
                    end else begin
                        sz[d][l] = int'($urandom % 5);
                    end
                end
                if (nlv[d] > 0) total = total * sz[d][nlv[d]-1];
            end
            build_slots(1'b0);
            if (n > 0 && total <= 400) break;
        end
        if (n == 0 || n > 18) begin
            clear_cfg();
            nlv[2] = 1; sz[2][0] = 3;
        end
        build_slots(1'b1);
    endtask

    task automatic run_cfg(input string tag, input bit rnd_ready, input bit mid_start);
        int ext [6];
        int idx [18];
        int total, redtot, beats, guard;
        bit first, hold;
        logic [15:0] hv [6];
        total = 1;
        for (int d = 0; d < 6; d++) begin
            ext[d] = 1;
            for (int s = 0; s < n; s++)
                if (sd[s] == d && sz[d][sl[s]] > ext[d]) ext[d] = sz[d][sl[s]];
            total = total * ext[d];
        end
        redtot = ext[0] * ext[1] * ext[4];
        for (int s = 0; s < 18; s++) idx[s] = 0;
        seen_map.delete();
        apply_cfg();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; #1;
        chk(out_valid == 1'b0, "R2", "valid in check cycle", out_valid, 0);
        chk(cfg_err == 1'b0, "R10", "error cleared by start", cfg_err, 0);
        beats = 0; guard = 0; first = 1; hold = 0;
        while (beats < total && guard < total * 8 + 100) begin
            @(negedge clk);
            out_ready = rnd_ready ? ($urandom % 3 != 0) : 1'b1;
            if (mid_start && beats == 3) begin
                start = 1'b1; cfg_size = '0; cfg_nloops = '0;
            end else begin
                start = 1'b0;
            end
            #1;
            if (first) begin
                chk(out_valid == 1'b1, "R2", "valid two cycles after start", out_valid, 1);
                first = 0;
            end
            if (hold) begin
                chk(out_valid && x == hv[0] && y == hv[1] && c == hv[2] &&
                    k == hv[3] && fw == hv[4] && fh == hv[5],
                    "R5", "tuple held under back-pressure", x, hv[0]);
                hold = 0;
            end
            if (out_valid && !out_ready) begin
                hold = 1;
                hv[0] = x; hv[1] = y; hv[2] = c; hv[3] = k; hv[4] = fw; hv[5] = fh;
            end
            if (out_valid && out_ready) begin
                int ex [6];
                longint key;
                int cnt;
                for (int d = 0; d < 6; d++) ex[d] = 0;
                for (int s = 0; s < n; s++) ex[sd[s]] += idx[s] * stp(s);
                chk(fw == 16'(ex[0]), "R3", {tag, " fw"}, fw, ex[0]);
                chk(fh == 16'(ex[1]), "R3", {tag, " fh"}, fh, ex[1]);
                chk(x  == 16'(ex[2]), "R3", {tag, " x"}, x, ex[2]);
                chk(y  == 16'(ex[3]), "R3", {tag, " y"}, y, ex[3]);
                chk(c  == 16'(ex[4]), "R3", {tag, " c"}, c, ex[4]);
                chk(k  == 16'(ex[5]), "R3", {tag, " k"}, k, ex[5]);
                chk(in_x == 17'(ex[2] + ex[0]), "R7", "input column", in_x, ex[2] + ex[0]);
                chk(in_y == 17'(ex[3] + ex[1]), "R7", "input row", in_y, ex[3] + ex[1]);
                key = (longint'(ex[2]) << 32) | (longint'(ex[3]) << 16) | longint'(ex[5]);
                cnt = seen_map.exists(key) ? seen_map[key] : 0;
                chk(red_first == (cnt == 0), "R6", "first flag", red_first, cnt == 0);
                chk(red_last == (cnt + 1 == redtot), "R6", "last flag", red_last, cnt + 1 == redtot);
                seen_map[key] = cnt + 1;
                for (int s = 0; s < n; s++) begin
                    idx[s]++;
                    if (idx[s] < sz[sd[s]][sl[s]] / stp(s)) break;
                    idx[s] = 0;
                end
                beats++;
            end
            guard++;
        end
        chk(beats == total, "R3", {tag, " tuple count"}, beats, total);
        @(negedge clk); start = 1'b0; #1;
        chk(done == 1'b1, "R8", "done after last accept", done, 1);
        chk(out_valid == 1'b0, "R8", "valid low after last accept", out_valid, 0);
        @(negedge clk); #1;
        chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
    endtask

    task automatic run_err(input string tag);
        apply_cfg();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); #1;
        chk(cfg_err == 1'b1, tag, "error flag", cfg_err, 1);
        chk(out_valid == 1'b0, tag, "no tuple on error", out_valid, 0);
        repeat (3) begin
            @(negedge clk); #1;
            chk(out_valid == 1'b0 && cfg_err == 1'b1, tag, "stays quiet", out_valid, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(cfg_err == 1'b0, "R1", "error after reset", cfg_err, 0);

        // R3 R9: default single-level order, start pulsed mid-run
        clear_cfg();
        for (int d = 0; d < 6; d++) nlv[d] = 1;
        sz[0][0] = 3; sz[1][0] = 2; sz[2][0] = 4; sz[3][0] = 3; sz[4][0] = 2; sz[5][0] = 2;
        build_slots(1'b0);
        run_cfg("R9 default order", 1'b1, 1'b1);

        // R3 R6: two-level splits in a mixed order
        clear_cfg();
        nlv[0] = 1; sz[0][0] = 3;
        nlv[2] = 2; sz[2][0] = 2; sz[2][1] = 6;
        nlv[4] = 2; sz[4][0] = 2; sz[4][1] = 4;
        nlv[5] = 1; sz[5][0] = 2;
        n = 6;
        sd[0] = 2; sl[0] = 0; sd[1] = 4; sl[1] = 0; sd[2] = 0; sl[2] = 0;
        sd[3] = 2; sl[3] = 1; sd[4] = 4; sl[4] = 1; sd[5] = 5; sl[5] = 0;
        run_cfg("R6 two-level", 1'b1, 1'b0);

        // R4: only output column and kernel used
        clear_cfg();
        nlv[2] = 1; sz[2][0] = 5; nlv[5] = 1; sz[5][0] = 3;
        n = 2; sd[0] = 5; sl[0] = 0; sd[1] = 2; sl[1] = 0;
        run_cfg("R4 absent dims", 1'b0, 1'b0);

        // R3: three levels listed out of order
        clear_cfg();
        nlv[3] = 3; sz[3][0] = 1; sz[3][1] = 2; sz[3][2] = 4;
        nlv[4] = 1; sz[4][0] = 3;
        n = 4;
        sd[0] = 3; sl[0] = 2; sd[1] = 4; sl[1] = 0; sd[2] = 3; sl[2] = 0; sd[3] = 3; sl[3] = 1;
        run_cfg("R3 three-level", 1'b1, 1'b0);

        // R10: non-multiple and zero sizes
        clear_cfg();
        nlv[2] = 2; sz[2][0] = 2; sz[2][1] = 5; build_slots(1'b0);
        run_err("R10");
        clear_cfg();
        nlv[4] = 1; sz[4][0] = 0; build_slots(1'b0);
        run_err("R10");

        // R11: slot list faults
        clear_cfg();
        nlv[2] = 1; sz[2][0] = 3; build_slots(1'b0);
        n = 0;
        run_err("R11");
        clear_cfg();
        sz[2][0] = 3; n = 2; sd[0] = 2; sl[0] = 0; sd[1] = 2; sl[1] = 0;
        run_err("R11");
        clear_cfg();
        sz[2][0] = 2; sz[2][1] = 4; n = 1; sd[0] = 2; sl[0] = 1;
        run_err("R11");
        clear_cfg();
        sz[2][0] = 2; n = 1; sd[0] = 7; sl[0] = 0;
        run_err("R11");
        clear_cfg();
        sz[2][0] = 2; n = 1; sd[0] = 2; sl[0] = 3;
        run_err("R11");

        // R3 R5 R6: random nests under random back-pressure
        for (int t = 0; t < 25; t++) begin
            clear_cfg();
            rand_cfg();
            run_cfg("R5 random", 1'b1, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule